// File: doc/BRIEF.md
# Multi-Precision Floating-Point Maximum-Number Unit

This unit takes two 128-bit register values and returns the greater of the two floating-point numbers held in their low element. The element can be half, single or double precision. NaNs follow the IEEE 754 maxNum rule: when one operand is a quiet NaN and the other is a number, the number wins. Signalling NaNs raise the invalid flag and produce the default quiet NaN. An optional flush mode turns subnormal inputs into signed zeros before the comparison and reports that it did so.

The answer goes into the low element of a 128-bit result. The bits above that element are either copied from the first operand or cleared. A request is presented with a one-cycle strobe, and the result, flags and an output-valid pulse appear on the next clock. When floating-point support is reported absent, or when the format code is the unused one, the unit produces no value. It signals an undefined operation instead.

Top module: `fpmax_unit`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high. In every other cycle it is low. After reset, `outValid`, `result`, `flagInvalid`, `flagDenormIn` and `undefOp` are all zero.
- R2: `fmtSel` chooses the element width. 2'b11 selects 16-bit half precision (5 exponent bits, 10 fraction bits). 2'b00 selects 32-bit single precision (8 and 23). 2'b01 selects 64-bit double precision (11 and 52). Each element has its sign in its top bit.
- R3: Numbers are ordered by sign and then by magnitude. A positive value beats a negative value. Of two positives, the larger magnitude wins. Of two negatives, the smaller magnitude wins. An infinity is ordered as the largest magnitude.
- R4: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the fraction's top bit is 1. When exactly one operand is a quiet NaN and the other is not a NaN, the result is the non-NaN operand and `flagInvalid` stays low.
- R5: When both operands are NaN, the result element is the default quiet NaN. This has sign 0, an all-ones exponent, a fraction top bit of 1 and all other bits 0: 16'h7E00, 32'h7FC00000 or 64'h7FF8000000000000.
- R6: A signalling NaN has a fraction top bit of 0 and a nonzero fraction. If either operand is a signalling NaN, `flagInvalid` is raised and the result element is the default quiet NaN.
- R7: Comparing +0 with -0 gives +0 in either operand order. Two -0 operands give -0.
- R8: A subnormal has a zero exponent and a nonzero fraction. With `flushEn` high, a subnormal operand is replaced by a zero of the same sign before the comparison, and `flagDenormIn` is raised. With `flushEn` low, subnormals are compared by value and `flagDenormIn` stays low.
- R9: With `mergeEn` high, the result bits above the element width are copied from `opA`. With `mergeEn` low, they are zero.
- R10: When `fpPresent` is low or `fmtSel` is 2'b10, the response has `undefOp` high, `result` zero and both exception flags low. Otherwise `undefOp` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| fmtSel | input | 2 | Element format code |
| mergeEn | input | 1 | Keep upper bits of `opA` in the result |
| flushEn | input | 1 | Treat subnormal inputs as signed zero |
| fpPresent | input | 1 | Floating-point support available |
| opA | input | 128 | First operand register value |
| opB | input | 128 | Second operand register value |
| outValid | output | 1 | Result valid pulse |
| result | output | 128 | Result register value |
| flagInvalid | output | 1 | Invalid-operation exception flag |
| flagDenormIn | output | 1 | Input-denormal exception flag |
| undefOp | output | 1 | Operation undefined, no result produced |

## Verification
The assertions watch, on every cycle, the one-cycle latency of the valid pulse and the handling of the upper bits for the merge and zeroing cases. They also check that an undefined response carries a zero result and no flags, and that the denormal flag only follows a request made with flushing enabled. The ordering of values, the choice between NaNs and numbers, the default NaN pattern and the signed-zero rule depend on the operand encodings. Those can only be shown by the bench's directed operand pairs, which cover each format and both operand orders.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_RSVD   = 2'b10,
    FMT_HALF   = 2'b11
  } fpFmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic undef;
  } ctrlStrobe_t;

  // widest element supported
  localparam int ELEM_MAX = 64;
  localparam int MAG_W    = ELEM_MAX - 1;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             isNan;
    logic             isSnan;
    logic             isDenorm;
  } fpOperand_t;

endpackage

// File: rtl/fpmax_ctrl.sv
module fpmax_ctrl
  import fpmax_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  fmtSel,
  input  logic        fpPresent,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.load  = inValid;
    strobe.undef = !fpPresent || (fpFmt_e'(fmtSel) == FMT_RSVD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/fpmax_dp.sv
module fpmax_dp
  import fpmax_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        fmtSel,
  input  logic              mergeEn,
  input  logic              flushEn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              flagInvalid,
  output logic              flagDenormIn,
  output logic              undefOp
);

  function automatic fpOperand_t unpackOp(input logic [1:0] fmt,
                                          input logic [DATA_W-1:0] v,
                                          input logic flush);
    fpOperand_t o;
    logic [MAG_W-1:0] mag;
    logic expOnes, expZero, fracNz, fracTop;
    case (fpFmt_e'(fmt))
      FMT_HALF: begin
        o.sign = v[15]; mag = MAG_W'(v[14:0]);
        expOnes = &v[14:10]; expZero = ~|v[14:10];
        fracNz = |v[9:0]; fracTop = v[9];
      end
      FMT_DOUBLE: begin
        o.sign = v[63]; mag = v[62:0];
        expOnes = &v[62:52]; expZero = ~|v[62:52];
        fracNz = |v[51:0]; fracTop = v[51];
      end
      default: begin
        o.sign = v[31]; mag = MAG_W'(v[30:0]);
        expOnes = &v[30:23]; expZero = ~|v[30:23];
        fracNz = |v[22:0]; fracTop = v[22];
      end
    endcase
    o.isNan    = expOnes & fracNz;
    o.isSnan   = o.isNan & ~fracTop;
    o.isDenorm = expZero & fracNz;
    o.mag      = (flush && o.isDenorm) ? '0 : mag;
    return o;
  endfunction

  function automatic logic [ELEM_MAX-1:0] packElem(input logic [1:0] fmt,
                                                   input logic s,
                                                   input logic [MAG_W-1:0] m);
    case (fpFmt_e'(fmt))
      FMT_HALF:   return ELEM_MAX'({s, m[14:0]});
      FMT_DOUBLE: return {s, m[62:0]};
      default:    return ELEM_MAX'({s, m[30:0]});
    endcase
  endfunction

  function automatic logic [ELEM_MAX-1:0] defaultNan(input logic [1:0] fmt);
    case (fpFmt_e'(fmt))
      FMT_HALF:   return ELEM_MAX'(16'h7E00);
      FMT_DOUBLE: return 64'h7FF8_0000_0000_0000;
      default:    return ELEM_MAX'(32'h7FC0_0000);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] elemMask(input logic [1:0] fmt);
    case (fpFmt_e'(fmt))
      FMT_HALF:   return DATA_W'(16'hFFFF);
      FMT_DOUBLE: return DATA_W'({ELEM_MAX{1'b1}});
      default:    return DATA_W'(32'hFFFF_FFFF);
    endcase
  endfunction

  fpOperand_t aOp, bOp;
  logic pickA, anySnan, bothNan;
  logic [ELEM_MAX-1:0] winElem;
  logic [DATA_W-1:0] nextResult;

  always_comb begin
    aOp     = unpackOp(fmtSel, opA, flushEn);
    bOp     = unpackOp(fmtSel, opB, flushEn);
    anySnan = aOp.isSnan | bOp.isSnan;
    bothNan = aOp.isNan & bOp.isNan;

    if (aOp.isNan != bOp.isNan)  pickA = bOp.isNan;
    else if (aOp.sign != bOp.sign) pickA = !aOp.sign;
    else if (!aOp.sign)          pickA = aOp.mag >= bOp.mag;
    else                         pickA = aOp.mag <= bOp.mag;

    if (anySnan || bothNan) winElem = defaultNan(fmtSel);
    else if (pickA)         winElem = packElem(fmtSel, aOp.sign, aOp.mag);
    else                    winElem = packElem(fmtSel, bOp.sign, bOp.mag);

    nextResult = (mergeEn ? (opA & ~elemMask(fmtSel)) : '0)
               | (DATA_W'(winElem) & elemMask(fmtSel));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      flagInvalid  <= 1'b0;
      flagDenormIn <= 1'b0;
      undefOp      <= 1'b0;
    end else if (strobe.load) begin
      undefOp <= strobe.undef;
      if (strobe.undef) begin
        result       <= '0;
        flagInvalid  <= 1'b0;
        flagDenormIn <= 1'b0;
      end else begin
        result       <= nextResult;
        flagInvalid  <= anySnan;
        flagDenormIn <= flushEn & (aOp.isDenorm | bOp.isDenorm);
      end
    end
  end

endmodule

// File: rtl/fpmax_unit.sv
module fpmax_unit
  import fpmax_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        fmtSel,
  input  logic              mergeEn,
  input  logic              flushEn,
  input  logic              fpPresent,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagInvalid,
  output logic              flagDenormIn,
  output logic              undefOp
);

  ctrlStrobe_t strobe;

  fpmax_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel),
    .fpPresent(fpPresent), .strobe(strobe), .outValid(outValid)
  );

  fpmax_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fmtSel(fmtSel),
    .mergeEn(mergeEn), .flushEn(flushEn), .opA(opA), .opB(opB),
    .result(result), .flagInvalid(flagInvalid),
    .flagDenormIn(flagDenormIn), .undefOp(undefOp)
  );

endmodule

// File: rtl/fpmax_chk.sv
module fpmax_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        fmtSel,
  input logic              mergeEn,
  input logic              flushEn,
  input logic [DATA_W-1:0] opA,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              flagInvalid,
  input logic              flagDenormIn,
  input logic              undefOp
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r9_merge_single: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mergeEn && fmtSel == 2'b00) |=>
      (undefOp || result[DATA_W-1:32] == $past(opA[DATA_W-1:32])));

  a_r9_zero_upper_double: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !mergeEn && fmtSel == 2'b01) |=> (result[DATA_W-1:64] == '0));

  a_r10_undef_empty: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && undefOp) |-> (result == '0 && !flagInvalid && !flagDenormIn));

  a_r8_denorm_needs_flush: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !flushEn) |=> !flagDenormIn);

endmodule

bind fpmax_unit fpmax_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel),
  .mergeEn(mergeEn), .flushEn(flushEn), .opA(opA), .outValid(outValid),
  .result(result), .flagInvalid(flagInvalid), .flagDenormIn(flagDenormIn),
  .undefOp(undefOp)
);

// File: tb/sim_fpmax_unit.sv
module sim_fpmax_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] UPA = 128'hA5A5_5A5A_1234_5678_9ABC_DEF0_0F1E_2D3C;
  localparam logic [127:0] UPB = 128'h3C3C_C3C3_FEDC_BA98_7654_3210_F0E1_D2C3;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [1:0] fmtSel = 2'b00;
  logic mergeEn = 1'b0, flushEn = 1'b0, fpPresent = 1'b1;
  logic [127:0] opA = '0, opB = '0;
  logic outValid, flagInvalid, flagDenormIn, undefOp;
  logic [127:0] result;

  int checks = 0, errors = 0, sent = 0, seen = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic inv, den, und;
    string tag;
  } expItem_t;
  expItem_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpmax_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel),
    .mergeEn(mergeEn), .flushEn(flushEn), .fpPresent(fpPresent),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .flagInvalid(flagInvalid), .flagDenormIn(flagDenormIn), .undefOp(undefOp)
  );

  function automatic logic [127:0] place(input logic [1:0] f,
                                         input logic [127:0] base,
                                         input logic [63:0] e);
    int w;
    logic [127:0] m;
    w = (f == 2'b11) ? 16 : (f == 2'b01) ? 64 : 32;
    m = (128'(1) << w) - 1;
    return (base & ~m) | (128'(e) & m);
  endfunction

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b,
                      input logic m, input logic fl, input logic pres,
                      input logic [63:0] expElem, input logic eInv,
                      input logic eDen, input logic eUnd, input string tag);
    expItem_t it;
    @(negedge clk);
    fmtSel = f; mergeEn = m; flushEn = fl; fpPresent = pres;
    opA = place(f, UPA, a); opB = place(f, UPB, b);
    inValid = 1'b1;
    it.res = eUnd ? '0 : place(f, m ? UPA : '0, expElem);
    it.inv = eUnd ? 1'b0 : eInv;
    it.den = eUnd ? 1'b0 : eDen;
    it.und = eUnd;
    it.tag = tag;
    q.push_back(it);
    sent++;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      seen++;
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: unexpected outValid, actual 1 expected 0");
      end else begin
        expItem_t it;
        it = q.pop_front();
        check({it.tag, " result"}, result, it.res);
        check({it.tag, " flagInvalid"}, 128'(flagInvalid), 128'(it.inv));
        check({it.tag, " flagDenormIn"}, 128'(flagDenormIn), 128'(it.den));
        check({it.tag, " undefOp"}, 128'(undefOp), 128'(it.und));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outValid", 128'(outValid), 128'(0));
    check("R1 reset result", result, '0);
    check("R1 reset flags", 128'({flagInvalid, flagDenormIn, undefOp}), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", 128'(outValid), 128'(0));

    // R3 ordering, R2 formats
    send(2'b00, 64'h3F800000, 64'h40000000, 1, 0, 1, 64'h40000000, 0, 0, 0, "R3 single pos");
    send(2'b00, 64'hBF800000, 64'hC0000000, 0, 0, 1, 64'hBF800000, 0, 0, 0, "R3 single neg");
    send(2'b01, 64'h3FF8000000000000, 64'hC008000000000000, 0, 0, 1,
         64'h3FF8000000000000, 0, 0, 0, "R3 double mixed sign");
    send(2'b11, 64'h3C00, 64'h3800, 0, 0, 1, 64'h3C00, 0, 0, 0, "R2 half");
    send(2'b00, 64'h7F7FFFFF, 64'h7F800000, 0, 0, 1, 64'h7F800000, 0, 0, 0, "R3 infinity");
    // R4 quiet NaN vs number, both orders
    send(2'b00, 64'h7FC00001, 64'h40400000, 0, 0, 1, 64'h40400000, 0, 0, 0, "R4 qnan first");
    send(2'b01, 64'hC000000000000000, 64'hFFF8000000000003, 1, 0, 1,
         64'hC000000000000000, 0, 0, 0, "R4 qnan second");
    // R5 both NaN
    send(2'b01, 64'h7FF8000000000001, 64'hFFF8000000000002, 0, 0, 1,
         64'h7FF8000000000000, 0, 0, 0, "R5 both qnan double");
    // R6 signalling NaN
    send(2'b00, 64'h7F800001, 64'h3F800000, 0, 0, 1, 64'h7FC00000, 1, 0, 0, "R6 snan single");
    send(2'b11, 64'h7C01, 64'h7E00, 1, 0, 1, 64'h7E00, 1, 0, 0, "R6 snan half");
    // R7 signed zeros
    send(2'b00, 64'h00000000, 64'h80000000, 0, 0, 1, 64'h00000000, 0, 0, 0, "R7 +0,-0");
    send(2'b00, 64'h80000000, 64'h00000000, 0, 0, 1, 64'h00000000, 0, 0, 0, "R7 -0,+0");
    send(2'b00, 64'h80000000, 64'h80000000, 0, 0, 1, 64'h80000000, 0, 0, 0, "R7 -0,-0");
    // R8 flushing
    send(2'b00, 64'h00000001, 64'h80000001, 0, 1, 1, 64'h00000000, 0, 1, 0, "R8 flush pair");
    send(2'b00, 64'h80000005, 64'hBF800000, 0, 1, 1, 64'h80000000, 0, 1, 0, "R8 flush neg");
    send(2'b00, 64'h80000005, 64'hBF800000, 0, 0, 1, 64'h80000005, 0, 0, 0, "R8 no flush");
    send(2'b00, 64'h7FC00000, 64'h00000003, 0, 1, 1, 64'h00000000, 0, 1, 0, "R8 flush vs qnan");
    // R9 merge
    send(2'b01, 64'h4000000000000000, 64'h3FF0000000000000, 1, 0, 1,
         64'h4000000000000000, 0, 0, 0, "R9 merge double");
    send(2'b11, 64'hC000, 64'hBC00, 0, 0, 1, 64'hBC00, 0, 0, 0, "R9 zero upper half");
    // R10 undefined
    send(2'b00, 64'h3F800000, 64'h7F800001, 1, 1, 0, 64'h0, 0, 0, 1, "R10 no fp");
    send(2'b10, 64'h3F800000, 64'h40000000, 1, 0, 1, 64'h0, 0, 0, 1, "R10 reserved fmt");
    idle();
    @(negedge clk);
    check("R1 no extra pulse", 128'(outValid), 128'(0));
    repeat (3) @(negedge clk);
    check("R1 output count", 128'(seen), 128'(sent));
    check("R1 queue drained", 128'(q.size()), 128'(0));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule